// File: doc/BRIEF.md
# Register-File ALU with Flag Writeback

This block is the arithmetic and logic stage of a small 8-bit virtual machine. The machine has sixteen general registers, and the last of them also serves as the flag register. A caller presents an operation code, two register indices and an immediate byte, then raises `start` for one cycle. In that same clock edge the block reads both operands from its internal register file and writes the result back to the register named by the first index. It then updates the flag register when the operation calls for it.

Flags follow the machine's own conventions. Register add reports a carry. Both subtract directions report an inverted borrow: 1 means no borrow. The shifts report the bit they shift out. Immediate add and the bitwise operations leave the flag alone. When the destination is the flag register itself, the flag write is applied last and replaces the arithmetic result. An asynchronous read port lets the surrounding machine, or a test, observe any register.

Top module: `regalu`

## Requirements
- R1: Reset (`rst_n` low) clears all sixteen registers to zero and holds `done` low.
- R2: Opcode 1 writes Vx+Vy (modulo 256) to Vx and sets VF to 1 when the true sum exceeds 255, else to 0.
- R3: Opcode 0 writes Vx+imm (modulo 256) to Vx and leaves VF unchanged when x is not 15.
- R4: Opcodes 2, 3 and 4 write Vx OR Vy, Vx AND Vy and Vx XOR Vy to Vx, and leave VF unchanged when x is not 15.
- R5: Opcode 5 writes Vx−Vy (modulo 256) to Vx and sets VF to 1 when Vx ≥ Vy, else to 0.
- R6: Opcode 6 writes Vy−Vx (modulo 256) to Vx and sets VF to 1 when Vy ≥ Vx, else to 0.
- R7: Opcode 7 sets VF to bit 0 of Vx and writes Vx shifted right by one, with a zero filled in, to Vx.
- R8: Opcode 8 sets VF to bit 7 of Vx and writes Vx shifted left by one, with a zero filled in, to Vx.
- R9: When x is 15 and the opcode writes a flag (1, 5, 6, 7, 8), VF ends up holding the flag and not the arithmetic result.
- R10: `done` is high for exactly the one cycle that follows each cycle with `start` high. Registers change only on an edge where `start` is high.
- R11: Opcodes 9 to 15 change no register and still pulse `done`.
- R12: `rd_data` shows the current contents of the register selected by `rd_idx`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Operation code |
| xi | input | 4 | Destination / first operand register index |
| yi | input | 4 | Second operand register index |
| imm | input | 8 | Immediate byte |
| done | output | 1 | Completion pulse, one cycle after start |
| rd_idx | input | 4 | Observation port register index |
| rd_data | output | 8 | Observation port data |

## Verification
The bench builds the block with its defaults: 8-bit registers and sixteen of them. At that size every carry, borrow and shifted-out bit lands on the top register index, and the flag register's double role can be reached. Random operand values and register indices push the flag rules across thousands of cases. Directed cases pin down the edges: 0xFF plus 1, subtraction of equal values, shifts of 0x01 and 0x80, each flag-writing operation aimed at VF, and the unused opcodes.

// File: rtl/regalu.sv
module regalu #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [3:0]              op,
  input  logic [$clog2(NREG)-1:0] xi,
  input  logic [$clog2(NREG)-1:0] yi,
  input  logic [DW-1:0]           imm,
  output logic                    done,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] FLAG = IW'(NREG - 1);

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] a, b, res;
  logic          flg, fwr, rwr;
  logic [DW:0]   sum;

  assign a       = rf[xi];
  assign b       = rf[yi];
  assign sum     = {1'b0, a} + {1'b0, b};
  assign rd_data = rf[rd_idx];

  always_comb begin
    res = a;
    flg = 1'b0;
    fwr = 1'b0;
    rwr = 1'b1;
    case (op)
      4'd0: res = a + imm;
      4'd1: begin res = sum[DW-1:0]; flg = sum[DW]; fwr = 1'b1; end
      4'd2: res = a | b;
      4'd3: res = a & b;
      4'd4: res = a ^ b;
      4'd5: begin res = a - b; flg = (a >= b); fwr = 1'b1; end
      4'd6: begin res = b - a; flg = (b >= a); fwr = 1'b1; end
      4'd7: begin res = a >> 1; flg = a[0]; fwr = 1'b1; end
      4'd8: begin res = a << 1; flg = a[DW-1]; fwr = 1'b1; end
      default: rwr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done <= start;
      if (start && rwr) rf[xi] <= res;
      if (start && fwr) rf[FLAG] <= DW'(flg);
    end
  end
endmodule

module regalu_chk #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [3:0]              op,
  input logic [$clog2(NREG)-1:0] xi,
  input logic [$clog2(NREG)-1:0] yi,
  input logic                    done,
  input logic [DW-1:0]           rf [NREG]
);
  localparam int FL = NREG - 1;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_imm_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 4'd0 && xi != FL) |=> $stable(rf[FL]));
  assert_or_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 4'd2 && xi != FL) |=> rf[$past(xi)] == $past(rf[xi] | rf[yi]));
  assert_shr_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 4'd7) |=> rf[FL] == DW'($past(rf[xi][0])));
  assert_shl_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 4'd8) |=> rf[FL] == DW'($past(rf[xi][DW-1])));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(rf[0]));
endmodule

bind regalu regalu_chk #(.DW(DW), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .xi(xi), .yi(yi), .done(done), .rf(rf)
);

// File: tb/regalu_tb_top.sv
module regalu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = '0, xi = '0, yi = '0, rd_idx = '0;
  logic [7:0] imm = '0;
  logic       done;
  logic [7:0] rd_data;

  int total = 0, bad = 0;
  logic [7:0] mdl [16];

  always #10 clk = ~clk;

  regalu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .xi(xi), .yi(yi),
    .imm(imm), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] r, output logic [7:0] v);
    rd_idx = r;
    #1;
    v = rd_data;
  endtask

  function automatic void model(input logic [3:0] o, input logic [3:0] x,
                                input logic [3:0] y, input logic [7:0] im);
    logic [7:0] a, b;
    logic [8:0] s;
    a = mdl[x];
    b = mdl[y];
    case (o)
      4'd0: mdl[x] = a + im;
      4'd1: begin s = a + b; mdl[x] = s[7:0]; mdl[15] = {7'd0, s[8]}; end
      4'd2: mdl[x] = a | b;
      4'd3: mdl[x] = a & b;
      4'd4: mdl[x] = a ^ b;
      4'd5: begin mdl[x] = a - b; mdl[15] = (a >= b) ? 8'd1 : 8'd0; end
      4'd6: begin mdl[x] = b - a; mdl[15] = (b >= a) ? 8'd1 : 8'd0; end
      4'd7: begin mdl[x] = {1'b0, a[7:1]}; mdl[15] = {7'd0, a[0]}; end
      4'd8: begin mdl[x] = {a[6:0], 1'b0}; mdl[15] = {7'd0, a[7]}; end
      default: ;
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [3:0] x,
                     input logic [3:0] y, input logic [7:0] im, input string req);
    logic [7:0] v;
    @(negedge clk);
    op = o; xi = x; yi = y; imm = im; start = 1'b1;
    model(o, x, y, im);
    @(negedge clk);
    start = 1'b0;
    chk({req, "/R10 done"}, {7'd0, done}, 8'd1);
    peek(x, v);
    chk({req, " dest"}, v, mdl[x]);
    peek(4'd15, v);
    chk({req, " VF"}, v, mdl[15]);
  endtask

  task automatic setreg(input logic [3:0] r, input logic [7:0] v);
    run(4'd4, r, r, 8'd0, "R4 clear");
    run(4'd0, r, 4'd0, v, "R3 load");
  endtask

  task automatic scan(input string req);
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      peek(4'(i), v);
      chk({req, " scan/R12"}, v, mdl[i]);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) mdl[i] = 8'd0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {7'd0, done}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    scan("R1 reset");

    setreg(4'd1, 8'hFF); setreg(4'd2, 8'h01);
    run(4'd1, 4'd1, 4'd2, 8'd0, "R2 carry");
    setreg(4'd1, 8'h7F);
    run(4'd1, 4'd1, 4'd2, 8'd0, "R2 no carry");
    setreg(4'd15, 8'h05);
    run(4'd0, 4'd3, 4'd0, 8'hF0, "R3 imm keeps VF");
    run(4'd0, 4'd3, 4'd0, 8'h20, "R3 imm wrap");
    setreg(4'd4, 8'h05); setreg(4'd5, 8'h05);
    run(4'd5, 4'd4, 4'd5, 8'd0, "R5 equal");
    setreg(4'd4, 8'h03);
    run(4'd5, 4'd4, 4'd5, 8'd0, "R5 borrow");
    setreg(4'd4, 8'h03);
    run(4'd6, 4'd4, 4'd5, 8'd0, "R6 no borrow");
    run(4'd6, 4'd5, 4'd4, 8'd0, "R6 borrow");
    setreg(4'd6, 8'h01);
    run(4'd7, 4'd6, 4'd0, 8'd0, "R7 shr lsb");
    setreg(4'd6, 8'h80);
    run(4'd8, 4'd6, 4'd0, 8'd0, "R8 shl msb");
    setreg(4'd15, 8'hFF); setreg(4'd7, 8'h02);
    run(4'd1, 4'd15, 4'd7, 8'd0, "R9 add into VF");
    setreg(4'd15, 8'h02);
    run(4'd7, 4'd15, 4'd0, 8'd0, "R9 shr VF");
    setreg(4'd15, 8'h10);
    run(4'd5, 4'd15, 4'd7, 8'd0, "R9 sub into VF");
    for (int k = 9; k < 16; k++) run(4'(k), 4'(k - 8), 4'd2, 8'h33, "R11 unused op");
    scan("R11");

    @(negedge clk);
    chk("R10 idle done", {7'd0, done}, 8'd0);
    scan("R10 idle");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      o = ($urandom % 10 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      run(o, 4'($urandom), 4'($urandom), 8'($urandom), "R2-8 random");
      if (n % 500 == 0) scan("random");
    end
    scan("final");
    peek(4'd0, v);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule